// File: doc/BRIEF.md
# Integer Execute Unit with Instruction Decode

This block is the execute stage of a 32-bit load-store integer core. Each cycle it can accept one instruction word together with the two source operand values that the register file has already read. It decodes the major opcode and function fields and selects an immediate extension rule. It then computes the result, picks the destination register index, and decides whether the write may happen. The outputs are the result, the destination index, a write enable, a signed-overflow exception flag and an unknown-encoding flag.

The unit handles register-register and register-immediate arithmetic, bitwise logic, signed and unsigned set-on-less-than, constant and variable shifts, and load-upper-immediate. All computation is combinational. A single register stage holds the result bundle, so outputs appear on the clock edge after the instruction is presented. Memory access, branches and multiply/divide are handled by other units.

Top module: `int_exec_unit`

## Requirements
- R1: The field positions are: opcode in bits 31:26, first source index in 25:21, second source index in 20:16, register-form destination in 15:11, shift amount in 10:6 and function code in 5:0. Opcode 0 instructions write the index in bits 15:11. Immediate instructions write the index in bits 20:16.
- R2: With opcode 0, function 0x20 and 0x21 add the operands and 0x22 and 0x23 subtract the second operand from the first. Opcodes 0x08 and 0x09 add a sign-extended 16-bit immediate. Every sum and difference wraps modulo 2^32.
- R3: Function 0x20, function 0x22 and opcode 0x08 raise the overflow flag on signed overflow. The wrapped value still appears on the result port, and write enable is low. Function 0x21, function 0x23 and opcode 0x09 never raise the flag.
- R4: Function codes 0x24, 0x25 and 0x26 give AND, OR and XOR of the two operands. Opcodes 0x0C, 0x0D and 0x0E apply the same operations with a zero-extended immediate.
- R5: Function 0x2A and opcode 0x0A compare signed. Function 0x2B and opcode 0x0B compare unsigned, and opcode 0x0B sign-extends its immediate first. The result is 1 when the first operand is less, otherwise 0.
- R6: Functions 0x00, 0x02 and 0x03 shift the second operand left, right logical and right arithmetic by bits 10:6. Functions 0x04 and 0x06 shift left and right logical by the low 5 bits of the first operand. Only the arithmetic right shift fills with the sign bit.
- R7: Opcode 0x0F puts the 16-bit immediate in result bits 31:16 and zeros in bits 15:0.
- R8: A destination index of 0 never asserts write enable. This covers the all-zero instruction word, which gives result equal to the second operand with no write.
- R9: Any other opcode or function code raises the reserved flag and gives result 0. Write enable and the overflow flag both stay low.
- R10: Outputs are registered. The output valid signal repeats the input valid one cycle later. In a cycle without valid input, the result, index, write enable and both flags are 0 one cycle later. Reset clears all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction and operands are present |
| instr | input | 32 | Instruction word |
| src_a | input | 32 | Value of the first source register |
| src_b | input | 32 | Value of the second source register |
| out_valid | output | 1 | Registered result bundle is valid |
| result | output | 32 | Computed value |
| dst_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Register write permitted |
| ovf_exc | output | 1 | Signed overflow on a trapping add or subtract |
| rsvd_exc | output | 1 | Unknown encoding |

## Verification
Two functions can land on one instruction: the overflow trap and the destination-zero suppression. A trapping add whose operands overflow and whose destination field is 0 provokes both. The bench expects the flag to stay raised and the write to stay off, so the zero-index rule must not hide the exception. The reserved check and the all-zero word are also run alongside back-to-back issue. This confirms that each flag belongs to its own cycle.

// File: rtl/exu_pkg.sv
package exu_pkg;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
        ALU_SLT, ALU_SLTU, ALU_SLL, ALU_SRL, ALU_SRA, ALU_LUI
    } alu_op_e;

    typedef struct packed {
        alu_op_e    op;
        logic       use_imm;
        logic       imm_sext;
        logic       trap_ovf;
        logic       var_shamt;
        logic [4:0] dst;
        logic       legal;
    } exu_ctrl_t;

    localparam logic [5:0] OPC_SPECIAL = 6'h00;
    localparam logic [5:0] OPC_ADDI    = 6'h08;
    localparam logic [5:0] OPC_ADDIU   = 6'h09;
    localparam logic [5:0] OPC_SLTI    = 6'h0A;
    localparam logic [5:0] OPC_SLTIU   = 6'h0B;
    localparam logic [5:0] OPC_ANDI    = 6'h0C;
    localparam logic [5:0] OPC_ORI     = 6'h0D;
    localparam logic [5:0] OPC_XORI    = 6'h0E;
    localparam logic [5:0] OPC_LUI     = 6'h0F;

    localparam logic [5:0] FN_SLL  = 6'h00;
    localparam logic [5:0] FN_SRL  = 6'h02;
    localparam logic [5:0] FN_SRA  = 6'h03;
    localparam logic [5:0] FN_SLLV = 6'h04;
    localparam logic [5:0] FN_SRLV = 6'h06;
    localparam logic [5:0] FN_ADD  = 6'h20;
    localparam logic [5:0] FN_ADDU = 6'h21;
    localparam logic [5:0] FN_SUB  = 6'h22;
    localparam logic [5:0] FN_SUBU = 6'h23;
    localparam logic [5:0] FN_AND  = 6'h24;
    localparam logic [5:0] FN_OR   = 6'h25;
    localparam logic [5:0] FN_XOR  = 6'h26;
    localparam logic [5:0] FN_SLT  = 6'h2A;
    localparam logic [5:0] FN_SLTU = 6'h2B;

endpackage

// File: rtl/exu_decode.sv
module exu_decode
    import exu_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    input  logic [4:0] rt_idx,
    input  logic [4:0] rd_idx,
    output exu_ctrl_t  ctrl
);

    always_comb begin
        ctrl       = '0;
        ctrl.op    = ALU_ADD;
        ctrl.legal = 1'b1;
        if (opcode == OPC_SPECIAL) begin
            ctrl.dst = rd_idx;
            unique case (funct)
                FN_SLL:  ctrl.op = ALU_SLL;
                FN_SRL:  ctrl.op = ALU_SRL;
                FN_SRA:  ctrl.op = ALU_SRA;
                FN_SLLV: begin ctrl.op = ALU_SLL; ctrl.var_shamt = 1'b1; end
                FN_SRLV: begin ctrl.op = ALU_SRL; ctrl.var_shamt = 1'b1; end
                FN_ADD:  begin ctrl.op = ALU_ADD; ctrl.trap_ovf = 1'b1; end
                FN_ADDU: ctrl.op = ALU_ADD;
                FN_SUB:  begin ctrl.op = ALU_SUB; ctrl.trap_ovf = 1'b1; end
                FN_SUBU: ctrl.op = ALU_SUB;
                FN_AND:  ctrl.op = ALU_AND;
                FN_OR:   ctrl.op = ALU_OR;
                FN_XOR:  ctrl.op = ALU_XOR;
                FN_SLT:  ctrl.op = ALU_SLT;
                FN_SLTU: ctrl.op = ALU_SLTU;
                default: ctrl.legal = 1'b0;
            endcase
        end else begin
            ctrl.dst     = rt_idx;
            ctrl.use_imm = 1'b1;
            unique case (opcode)
                OPC_ADDI:  begin ctrl.op = ALU_ADD;  ctrl.imm_sext = 1'b1; ctrl.trap_ovf = 1'b1; end
                OPC_ADDIU: begin ctrl.op = ALU_ADD;  ctrl.imm_sext = 1'b1; end
                OPC_SLTI:  begin ctrl.op = ALU_SLT;  ctrl.imm_sext = 1'b1; end
                OPC_SLTIU: begin ctrl.op = ALU_SLTU; ctrl.imm_sext = 1'b1; end
                OPC_ANDI:  ctrl.op = ALU_AND;
                OPC_ORI:   ctrl.op = ALU_OR;
                OPC_XORI:  ctrl.op = ALU_XOR;
                OPC_LUI:   ctrl.op = ALU_LUI;
                default:   ctrl.legal = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/exu_addsub.sv
module exu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf,
    output logic         lt_s,
    output logic         lt_u
);

    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    assign b_eff = sub ? ~b : b;
    assign wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
    assign sum   = wide[W-1:0];
    assign ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    // Valid when sub is set: a borrow means a < b unsigned.
    assign lt_u  = ~wide[W];
    assign lt_s  = (a[W-1] != b[W-1]) ? a[W-1] : sum[W-1];

endmodule

// File: rtl/exu_shift.sv
module exu_shift #(
    parameter int W  = 32,
    parameter int SW = $clog2(W)
) (
    input  logic [W-1:0]  val,
    input  logic [SW-1:0] amt,
    input  logic          left,
    input  logic          arith,
    output logic [W-1:0]  out
);

    logic [W-1:0] stg [0:SW];
    logic         fill;

    assign fill   = arith & val[W-1];
    assign stg[0] = val;

    for (genvar g = 0; g < SW; g++) begin : g_stage
        localparam int P = 1 << g;
        logic [W-1:0] moved;
        assign moved = left ? (stg[g] << P)
                            : ((stg[g] >> P) | ({W{fill}} << (W - P)));
        assign stg[g+1] = amt[g] ? moved : stg[g];
    end

    assign out = stg[SW];

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import exu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     instr,
    input  logic [XLEN-1:0] src_a,
    input  logic [XLEN-1:0] src_b,
    output logic            out_valid,
    output logic [XLEN-1:0] result,
    output logic [4:0]      dst_idx,
    output logic            wr_en,
    output logic            ovf_exc,
    output logic            rsvd_exc
);

    localparam int SHW  = $clog2(XLEN);
    localparam int IMMW = 16;

    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] res;
        logic [4:0]      dst;
        logic            we;
        logic            ovf;
        logic            rsvd;
    } exu_out_t;

    exu_ctrl_t       ctrl;
    exu_out_t        out_d, out_q;
    logic [XLEN-1:0] imm_ext, opnd_b, sum, shifted;
    logic [SHW-1:0]  shamt;
    logic            ovf_raw, lt_s, lt_u, is_sub;
    logic            unused_rs;

    assign unused_rs = ^instr[25:21];

    exu_decode u_dec (
        .opcode (instr[31:26]),
        .funct  (instr[5:0]),
        .rt_idx (instr[20:16]),
        .rd_idx (instr[15:11]),
        .ctrl   (ctrl)
    );

    assign imm_ext = ctrl.imm_sext
                   ? {{(XLEN-IMMW){instr[IMMW-1]}}, instr[IMMW-1:0]}
                   : {{(XLEN-IMMW){1'b0}}, instr[IMMW-1:0]};
    assign opnd_b  = ctrl.use_imm ? imm_ext : src_b;
    assign is_sub  = (ctrl.op == ALU_SUB) || (ctrl.op == ALU_SLT) || (ctrl.op == ALU_SLTU);
    assign shamt   = ctrl.var_shamt ? src_a[SHW-1:0] : instr[6+SHW-1:6];

    exu_addsub #(.W(XLEN)) u_add (
        .a    (src_a),
        .b    (opnd_b),
        .sub  (is_sub),
        .sum  (sum),
        .ovf  (ovf_raw),
        .lt_s (lt_s),
        .lt_u (lt_u)
    );

    exu_shift #(.W(XLEN), .SW(SHW)) u_shf (
        .val   (src_b),
        .amt   (shamt),
        .left  (ctrl.op == ALU_SLL),
        .arith (ctrl.op == ALU_SRA),
        .out   (shifted)
    );

    always_comb begin
        out_d = '0;
        if (in_valid) begin
            out_d.vld = 1'b1;
            if (ctrl.legal) begin
                unique case (ctrl.op)
                    ALU_ADD, ALU_SUB: out_d.res = sum;
                    ALU_AND:          out_d.res = src_a & opnd_b;
                    ALU_OR:           out_d.res = src_a | opnd_b;
                    ALU_XOR:          out_d.res = src_a ^ opnd_b;
                    ALU_SLT:          out_d.res = {{(XLEN-1){1'b0}}, lt_s};
                    ALU_SLTU:         out_d.res = {{(XLEN-1){1'b0}}, lt_u};
                    ALU_SLL, ALU_SRL,
                    ALU_SRA:          out_d.res = shifted;
                    ALU_LUI:          out_d.res = {instr[IMMW-1:0], {(XLEN-IMMW){1'b0}}};
                    default:          out_d.res = '0;
                endcase
                out_d.dst = ctrl.dst;
                out_d.ovf = ctrl.trap_ovf && ovf_raw;
                out_d.we  = (ctrl.dst != 5'd0) && !out_d.ovf;
            end else begin
                out_d.rsvd = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid = out_q.vld;
    assign result    = out_q.res;
    assign dst_idx   = out_q.dst;
    assign wr_en     = out_q.we;
    assign ovf_exc   = out_q.ovf;
    assign rsvd_exc  = out_q.rsvd;

endmodule

// File: rtl/exu_checker.sv
module exu_checker #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [31:0]     instr,
    input logic            out_valid,
    input logic [XLEN-1:0] result,
    input logic [4:0]      dst_idx,
    input logic            wr_en,
    input logic            ovf_exc,
    input logic            rsvd_exc
);

    AST_OVF_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_exc |-> !wr_en); // R3

    AST_ZERO_DST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (dst_idx != 5'd0)); // R8

    AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_exc |-> (!wr_en && !ovf_exc && result == '0)); // R9

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (!wr_en && !ovf_exc && !rsvd_exc)); // R10

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R10

    AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R10

    AST_LUI_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && instr[31:26] == 6'h0F) |=> (result[15:0] == 16'h0 && !ovf_exc)); // R7

    AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_exc && rsvd_exc)); // R9

endmodule

bind int_exec_unit exu_checker #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .instr     (instr),
    .out_valid (out_valid),
    .result    (result),
    .dst_idx   (dst_idx),
    .wr_en     (wr_en),
    .ovf_exc   (ovf_exc),
    .rsvd_exc  (rsvd_exc)
);

// File: tb/tb_int_exec_unit.sv
`timescale 1ns/1ps
module tb_int_exec_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic        out_valid;
    logic [31:0] result;
    logic [4:0]  dst_idx;
    logic        wr_en, ovf_exc, rsvd_exc;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    int_exec_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result),
        .dst_idx(dst_idx), .wr_en(wr_en), .ovf_exc(ovf_exc), .rsvd_exc(rsvd_exc)
    );

    function automatic logic [31:0] rtype(input logic [5:0] fn, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [4:0] rd,
                                          input logic [4:0] sh);
        return {6'h00, rs, rt, rd, sh, fn};
    endfunction

    function automatic logic [31:0] itype(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic compare(input string tag, input logic vld, input logic [31:0] res,
                           input logic [4:0] dst, input logic we, input logic ovf,
                           input logic rsvd);
        logic [40:0] act, exp;
        act = {out_valid, result, dst_idx, wr_en, ovf_exc, rsvd_exc};
        exp = {vld, res, dst, we, ovf, rsvd};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual v=%0b res=%h dst=%0d we=%0b ovf=%0b rsvd=%0b expected v=%0b res=%h dst=%0d we=%0b ovf=%0b rsvd=%0b",
                     tag, out_valid, result, dst_idx, wr_en, ovf_exc, rsvd_exc,
                     vld, res, dst, we, ovf, rsvd);
        end
    endtask

    // Drive at a falling edge, let one rising edge register it, check at the next falling edge.
    task automatic run(input string tag, input logic [31:0] ins, input logic [31:0] a,
                       input logic [31:0] b, input logic [31:0] res, input logic [4:0] dst,
                       input logic we, input logic ovf, input logic rsvd);
        in_valid = 1'b1; instr = ins; src_a = a; src_b = b;
        @(posedge clk);
        @(negedge clk);
        compare(tag, 1'b1, res, dst, we, ovf, rsvd);
    endtask

    task automatic t_reset;
        @(negedge clk);
        compare("R10 reset", 1'b0, 32'h0, 5'd0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_addsub;
        run("R1 R2 add rd", rtype(6'h20, 5'd1, 5'd2, 5'd3, 5'd0), 32'd5, 32'd7, 32'd12, 5'd3, 1, 0, 0);
        run("R1 R2 addi rt", itype(6'h08, 5'd1, 5'd9, 16'hFFFF), 32'd10, 32'hDEAD, 32'd9, 5'd9, 1, 0, 0);
        run("R2 addu wrap", rtype(6'h21, 5'd1, 5'd2, 5'd4, 5'd0), 32'h7FFFFFFF, 32'd1, 32'h80000000, 5'd4, 1, 0, 0);
        run("R2 addiu sext", itype(6'h09, 5'd1, 5'd5, 16'h0001), 32'h7FFFFFFF, 32'd0, 32'h80000000, 5'd5, 1, 0, 0);
        run("R2 addiu neg", itype(6'h09, 5'd1, 5'd5, 16'hFFFE), 32'd1, 32'd0, 32'hFFFFFFFF, 5'd5, 1, 0, 0);
        run("R2 subu wrap", rtype(6'h23, 5'd1, 5'd2, 5'd6, 5'd0), 32'd0, 32'd1, 32'hFFFFFFFF, 5'd6, 1, 0, 0);
        run("R2 sub plain", rtype(6'h22, 5'd1, 5'd2, 5'd6, 5'd0), 32'd5, 32'd3, 32'd2, 5'd6, 1, 0, 0);
    endtask

    task automatic t_overflow;
        run("R3 add ovf", rtype(6'h20, 5'd1, 5'd2, 5'd7, 5'd0), 32'h7FFFFFFF, 32'd1, 32'h80000000, 5'd7, 0, 1, 0);
        run("R3 sub ovf", rtype(6'h22, 5'd1, 5'd2, 5'd7, 5'd0), 32'h80000000, 32'd1, 32'h7FFFFFFF, 5'd7, 0, 1, 0);
        run("R3 addi ovf", itype(6'h08, 5'd1, 5'd8, 16'hFFFF), 32'h80000000, 32'd0, 32'h7FFFFFFF, 5'd8, 0, 1, 0);
        run("R3 R8 add ovf to reg0", rtype(6'h20, 5'd1, 5'd2, 5'd0, 5'd0), 32'h40000000, 32'h40000000, 32'h80000000, 5'd0, 0, 1, 0);
    endtask

    task automatic t_logic;
        run("R4 and", rtype(6'h24, 5'd1, 5'd2, 5'd10, 5'd0), 32'hF0F01234, 32'h0FF0FF00, 32'h00F01200, 5'd10, 1, 0, 0);
        run("R4 or",  rtype(6'h25, 5'd1, 5'd2, 5'd10, 5'd0), 32'hF0F01234, 32'h0FF0FF00, 32'hFFF0FF34, 5'd10, 1, 0, 0);
        run("R4 xor", rtype(6'h26, 5'd1, 5'd2, 5'd10, 5'd0), 32'hF0F01234, 32'h0FF0FF00, 32'hFF00ED34, 5'd10, 1, 0, 0);
        run("R4 andi zext", itype(6'h0C, 5'd1, 5'd11, 16'h8001), 32'hFFFFFFFF, 32'd0, 32'h00008001, 5'd11, 1, 0, 0);
        run("R4 ori zext", itype(6'h0D, 5'd1, 5'd11, 16'h8000), 32'd0, 32'd0, 32'h00008000, 5'd11, 1, 0, 0);
        run("R4 xori zext", itype(6'h0E, 5'd1, 5'd11, 16'hFFFF), 32'hFFFF0000, 32'd0, 32'hFFFFFFFF, 5'd11, 1, 0, 0);
    endtask

    task automatic t_compare;
        run("R5 slt signed", rtype(6'h2A, 5'd1, 5'd2, 5'd12, 5'd0), 32'hFFFFFFFF, 32'd1, 32'd1, 5'd12, 1, 0, 0);
        run("R5 sltu unsigned", rtype(6'h2B, 5'd1, 5'd2, 5'd12, 5'd0), 32'hFFFFFFFF, 32'd1, 32'd0, 5'd12, 1, 0, 0);
        run("R5 slt equal", rtype(6'h2A, 5'd1, 5'd2, 5'd12, 5'd0), 32'd9, 32'd9, 32'd0, 5'd12, 1, 0, 0);
        run("R5 slti", itype(6'h0A, 5'd1, 5'd13, 16'hFFFF), 32'hFFFFFFFE, 32'd0, 32'd1, 5'd13, 1, 0, 0);
        run("R5 sltiu sext", itype(6'h0B, 5'd1, 5'd13, 16'hFFFF), 32'd5, 32'd0, 32'd1, 5'd13, 1, 0, 0);
        run("R5 sltiu equal", itype(6'h0B, 5'd1, 5'd13, 16'hFFFF), 32'hFFFFFFFF, 32'd0, 32'd0, 5'd13, 1, 0, 0);
    endtask

    task automatic t_shift;
        run("R6 sll", rtype(6'h00, 5'd0, 5'd2, 5'd14, 5'd4), 32'd0, 32'h000000F1, 32'h00000F10, 5'd14, 1, 0, 0);
        run("R6 srl", rtype(6'h02, 5'd0, 5'd2, 5'd14, 5'd4), 32'd0, 32'h80000000, 32'h08000000, 5'd14, 1, 0, 0);
        run("R6 sra", rtype(6'h03, 5'd0, 5'd2, 5'd14, 5'd4), 32'd0, 32'h80000000, 32'hF8000000, 5'd14, 1, 0, 0);
        run("R6 sra 31", rtype(6'h03, 5'd0, 5'd2, 5'd14, 5'd31), 32'd0, 32'h80000000, 32'hFFFFFFFF, 5'd14, 1, 0, 0);
        run("R6 sllv low5", rtype(6'h04, 5'd1, 5'd2, 5'd15, 5'd9), 32'h00000023, 32'd1, 32'd8, 5'd15, 1, 0, 0);
        run("R6 srlv low5", rtype(6'h06, 5'd1, 5'd2, 5'd15, 5'd0), 32'hFFFFFFE1, 32'h80000000, 32'h40000000, 5'd15, 1, 0, 0);
    endtask

    task automatic t_lui;
        run("R7 lui", itype(6'h0F, 5'd7, 5'd4, 16'hABCD), 32'h12345678, 32'h0, 32'hABCD0000, 5'd4, 1, 0, 0);
    endtask

    task automatic t_zero_dst;
        run("R8 all-zero word", 32'h0, 32'h55, 32'h00001234, 32'h00001234, 5'd0, 0, 0, 0);
        run("R8 addu to reg0", rtype(6'h21, 5'd1, 5'd2, 5'd0, 5'd0), 32'd1, 32'd2, 32'd3, 5'd0, 0, 0, 0);
        run("R8 ori to reg0", itype(6'h0D, 5'd1, 5'd0, 16'h00FF), 32'd0, 32'd0, 32'h000000FF, 5'd0, 0, 0, 0);
    endtask

    task automatic t_reserved;
        run("R9 opcode 0x3F", itype(6'h3F, 5'd1, 5'd3, 16'h1234), 32'h7FFFFFFF, 32'd1, 32'd0, 5'd0, 0, 0, 1);
        run("R9 funct 0x01", rtype(6'h01, 5'd1, 5'd2, 5'd3, 5'd0), 32'h7FFFFFFF, 32'd1, 32'd0, 5'd0, 0, 0, 1);
        run("R9 load opcode", itype(6'h23, 5'd1, 5'd3, 16'h0004), 32'h10, 32'd0, 32'd0, 5'd0, 0, 0, 1);
    endtask

    task automatic t_idle;
        in_valid = 1'b0;
        instr = rtype(6'h20, 5'd1, 5'd2, 5'd3, 5'd0);
        src_a = 32'h7FFFFFFF; src_b = 32'd1;
        @(posedge clk);
        @(negedge clk);
        compare("R10 idle cycle", 1'b0, 32'h0, 5'd0, 1'b0, 1'b0, 1'b0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        rst_n = 1'b1;
        t_addsub();
        t_overflow();
        t_idle();
        t_logic();
        t_compare();
        t_shift();
        t_lui();
        t_zero_dst();
        t_reserved();
        t_addsub();
        t_idle();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule